// File: doc/BRIEF.md
# Multi-Ported Register File With Flash Invalidate

This block is a small register-file memory that offers more simultaneous write and read ports than a two-writer storage array can provide. Writers are grouped in pairs. Each pair feeds its own set of storage banks. A flop table records, for every entry, which bank received the latest write, and that record steers every read. Each read port has its own copy of every bank. Each copy receives the same writes, so no read port shares storage with another.

Beside the storage sits a per-entry valid array. A write sets the valid bit. A single-cycle flash invalidate clears every entry selected by a mask, and leaves the stored data untouched. A read of an invalid entry returns a fixed reset value. A typical use is speculative state that must be discarded in one cycle, for example after a branch mispredict. Reads are combinational from the registered state, so a write becomes visible on the cycle after it is made.

Top module: `mpram_flashinv`

## Requirements
- R1: After reset, every entry is invalid, and every read port returns RESET_VAL (default 8'hA5) for every address.
- R2: A write on any write port is returned, on the cycle after the write, by every read port that addresses that entry.
- R3: A read in the same cycle as a write to the same address returns the value the entry held before that write.
- R4: When several write ports write the same address in one cycle, the highest-numbered port's data is stored and the entry becomes valid. This holds within a pair of writers and across pairs.
- R5: When inv_en is high, every entry whose bit in inv_mask is set (bit i selects entry i) becomes invalid and reads return RESET_VAL. Entries whose mask bit is clear keep their valid state and data.
- R6: When a write and a flash invalidate hit the same entry in one cycle, the write wins: the entry ends valid and holds the written data.
- R7: Read ports are independent: in one cycle, each port returns the entry at its own address, under any mix of writes and invalidates.
- R8: With no write and no invalidate in the previous cycle and an unchanged address, a read port's output does not change.
- R9: A later write through a lower-numbered bank replaces an earlier write through a higher-numbered bank: the entry always reads back the most recent write, whatever bank holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_WR | Per-port write enable |
| wr_addr | input | NUM_WR*AW | Write addresses, port p in bits [p*AW +: AW] |
| wr_data | input | NUM_WR*DATA_W | Write data, port p in bits [p*DATA_W +: DATA_W] |
| inv_en | input | 1 | Flash invalidate strobe |
| inv_mask | input | DEPTH | Entries affected by the invalidate, bit i selects entry i |
| rd_addr | input | NUM_RD*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NUM_RD*DATA_W | Read data, port r in bits [r*DATA_W +: DATA_W] |

## Verification
The assertions assume that every write and read address is below DEPTH, so each write lands in exactly one table entry. They also assume that inputs are stable around the rising edge and that no write is offered while reset is held. The default DEPTH is a power of two, so every value the 4-bit address can take is a legal entry. The bench changes inputs only on the falling edge and keeps all enables low during reset. This keeps the stimulus inside those assumptions. The read-stability property additionally requires one full cycle after reset before it compares against past values.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

  // Writers are grouped in pairs; each pair owns one bank set.
  function automatic int unsigned bank_count(input int unsigned n_wr);
    return (n_wr + 1) / 2;
  endfunction

  // Bank that a given write port feeds.
  function automatic int unsigned bank_of(input int unsigned port);
    return port >> 1;
  endfunction

  // Lane (0 or 1) inside its bank.
  function automatic int unsigned lane_of(input int unsigned port);
    return port & 1;
  endfunction

  // Width of a bank selector, never below one bit.
  function automatic int unsigned sel_width(input int unsigned n_banks);
    return (n_banks > 1) ? $clog2(n_banks) : 1;
  endfunction

endpackage

// File: rtl/mpram_bank2w.sv
module mpram_bank2w #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we0,
  input  logic [AW-1:0]     wa0,
  input  logic [DATA_W-1:0] wd0,
  input  logic              we1,
  input  logic [AW-1:0]     wa1,
  input  logic [DATA_W-1:0] wd1,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage has no reset; lane 1 is written last so it wins a clash.
  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rd = mem[ra];

  wire lane_clash = we0 && we1 && (wa0 == wa1);

  assert_lane0_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && !lane_clash) |=> (mem[$past(wa0)] == $past(wd0)));

  assert_lane1_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we1 |=> (mem[$past(wa1)] == $past(wd1)));

endmodule

// File: rtl/mpram_newest_tbl.sv
module mpram_newest_tbl #(
  parameter int NUM_WR = 4,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int NB    = mpram_pkg::bank_count(NUM_WR),
  localparam int BW    = mpram_pkg::sel_width(NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WR-1:0]    wr_en,
  input  logic [NUM_WR*AW-1:0] wr_addr,
  output logic [DEPTH-1:0]     hit_vec,
  output logic [DEPTH*BW-1:0]  sel_flat
);

  logic [BW-1:0] sel_q   [DEPTH];
  logic [BW-1:0] sel_nxt [DEPTH];

  // Ports are scanned upward, so the highest-numbered hit decides.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sel_nxt[i] = sel_q[i];
      hit_vec[i] = 1'b0;
      for (int p = 0; p < NUM_WR; p++) begin
        if (wr_en[p] && (wr_addr[p*AW +: AW] == AW'(i))) begin
          sel_nxt[i] = BW'(mpram_pkg::bank_of(p));
          hit_vec[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) sel_q[i] <= '0;
      else        sel_q[i] <= sel_nxt[i];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_out
      assign sel_flat[gi*BW +: BW] = sel_q[gi];

      assert_tbl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vec[gi] |=> $stable(sel_q[gi]));

      assert_tbl_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[gi] |=> (int'(sel_q[gi]) < NB));
    end
  endgenerate

endmodule

// File: rtl/mpram_valid_arr.sv
module mpram_valid_arr #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] set_vec,
  input  logic [DEPTH-1:0] clr_vec,
  output logic [DEPTH-1:0] valid_q
);

  // Set dominates clear, so a write beats a same-cycle invalidate.
  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= (valid_q & ~clr_vec) | set_vec;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_chk
      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[gi] |=> valid_q[gi]);

      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[gi] && !set_vec[gi]) |=> !valid_q[gi]);

      assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_vec[gi] && !set_vec[gi]) |=> $stable(valid_q[gi]));
    end
  endgenerate

endmodule

// File: rtl/mpram_flashinv.sv
module mpram_flashinv #(
  parameter int                NUM_WR    = 4,
  parameter int                NUM_RD    = 3,
  parameter int                DEPTH     = 16,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'hA5,
  localparam int               AW        = $clog2(DEPTH),
  localparam int               NB        = mpram_pkg::bank_count(NUM_WR),
  localparam int               BW        = mpram_pkg::sel_width(NB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WR-1:0]        wr_en,
  input  logic [NUM_WR*AW-1:0]     wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic                     inv_en,
  input  logic [DEPTH-1:0]         inv_mask,
  input  logic [NUM_RD*AW-1:0]     rd_addr,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);

  // Named internal events for the checks.
  logic [DEPTH-1:0]    entry_hit;
  logic [DEPTH-1:0]    entry_clr;
  logic [DEPTH-1:0]    valid_q;
  logic [DEPTH*BW-1:0] sel_flat;
  logic [DATA_W-1:0]   bank_rd [NB][NUM_RD];
  wire                 any_wr = |wr_en;

  assign entry_clr = inv_en ? inv_mask : '0;

  mpram_newest_tbl #(.NUM_WR(NUM_WR), .DEPTH(DEPTH)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .hit_vec (entry_hit),
    .sel_flat(sel_flat)
  );

  mpram_valid_arr #(.DEPTH(DEPTH)) u_valid (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(entry_hit),
    .clr_vec(entry_clr),
    .valid_q(valid_q)
  );

  genvar gb, gr;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_bank
      localparam int P0 = 2 * gb;
      localparam int P1 = 2 * gb + 1;
      logic              we1;
      logic [AW-1:0]     wa1;
      logic [DATA_W-1:0] wd1;

      if (P1 < NUM_WR) begin : g_pair
        assign we1 = wr_en[P1];
        assign wa1 = wr_addr[P1*AW +: AW];
        assign wd1 = wr_data[P1*DATA_W +: DATA_W];
      end else begin : g_single
        assign we1 = 1'b0;
        assign wa1 = '0;
        assign wd1 = '0;
      end

      // One copy of this bank per read port, all fed the same writes.
      for (gr = 0; gr < NUM_RD; gr++) begin : g_copy
        mpram_bank2w #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
          .clk  (clk),
          .rst_n(rst_n),
          .we0  (wr_en[P0]),
          .wa0  (wr_addr[P0*AW +: AW]),
          .wd0  (wr_data[P0*DATA_W +: DATA_W]),
          .we1  (we1),
          .wa1  (wa1),
          .wd1  (wd1),
          .ra   (rd_addr[gr*AW +: AW]),
          .rd   (bank_rd[gb][gr])
        );
      end
    end
  endgenerate

  // Read steering: valid bit gates, newest-bank table selects the copy.
  always_comb begin
    for (int r = 0; r < NUM_RD; r++) begin
      logic [AW-1:0] a;
      logic [BW-1:0] s;
      a = rd_addr[r*AW +: AW];
      s = sel_flat[int'(a)*BW +: BW];
      rd_data[r*DATA_W +: DATA_W] = RESET_VAL;
      if (valid_q[a]) begin
        for (int b = 0; b < NB; b++) begin
          if (s == BW'(b)) rd_data[r*DATA_W +: DATA_W] = bank_rd[b][r];
        end
      end
    end
  end

  // One cycle of history after reset before comparing against the past.
  logic live_q;
  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  generate
    for (gr = 0; gr < NUM_RD; gr++) begin : g_rchk
      assert_read_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(any_wr) && !$past(inv_en) && $stable(rd_addr[gr*AW +: AW]))
          |-> $stable(rd_data[gr*DATA_W +: DATA_W]));
    end
  endgenerate

  assert_no_clr_at_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_en |-> (entry_clr == '0));

endmodule

// File: tb/mpram_flashinv_bench.sv
`timescale 1ns/1ps
module mpram_flashinv_bench;
  localparam int NW = 4, NR = 3, DEPTH = 16, DW = 8, AW = 4;
  localparam logic [DW-1:0] RV = 8'hA5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n;
  logic [NW-1:0]       wr_en;
  logic [AW-1:0]       wa [NW];
  logic [DW-1:0]       wd [NW];
  logic [AW-1:0]       ra [NR];
  logic                inv_en;
  logic [DEPTH-1:0]    inv_mask;
  logic [NW*AW-1:0]    wr_addr;
  logic [NW*DW-1:0]    wr_data;
  logic [NR*AW-1:0]    rd_addr;
  logic [NR*DW-1:0]    rd_data;

  always_comb begin
    for (int p = 0; p < NW; p++) begin
      wr_addr[p*AW +: AW] = wa[p];
      wr_data[p*DW +: DW] = wd[p];
    end
    for (int r = 0; r < NR; r++) rd_addr[r*AW +: AW] = ra[r];
  end

  mpram_flashinv u_mpram_flashinv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .inv_en(inv_en), .inv_mask(inv_mask),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Requirement model.
  logic [DW-1:0]    m_data [DEPTH];
  logic [DEPTH-1:0] m_val;
  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [DW-1:0] pat(input int p, input int a);
    return DW'(p * 37 + a * 11 + 3);
  endfunction

  task automatic cmp(input string tag, input int port, input int addr,
                     input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %0d addr %0d: got %h expected %h", tag, port, addr, got, exp);
    end
  endtask

  task automatic check_reads(input string tag);
    #1;
    for (int r = 0; r < NR; r++)
      cmp(tag, r, ra[r], rd_data[r*DW +: DW], m_val[ra[r]] ? m_data[ra[r]] : RV);
  endtask

  task automatic idle();
    wr_en = '0; inv_en = 1'b0; inv_mask = '0;
    for (int p = 0; p < NW; p++) begin wa[p] = '0; wd[p] = '0; end
  endtask

  // Apply the edge: invalidate first, then writes in ascending port order.
  task automatic tick();
    @(posedge clk);
    if (inv_en) m_val = m_val & ~inv_mask;
    for (int p = 0; p < NW; p++)
      if (wr_en[p]) begin m_data[wa[p]] = wd[p]; m_val[wa[p]] = 1'b1; end
    @(negedge clk);
  endtask

  task automatic set_all_reads(input int a);
    for (int r = 0; r < NR; r++) ra[r] = AW'(a);
  endtask

  logic [DW-1:0] hold [NR];

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; m_val = '0; idle(); set_all_reads(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything reads the reset value.
    for (int a = 0; a < DEPTH; a++) begin
      set_all_reads(a); #1;
      for (int r = 0; r < NR; r++) cmp("R1", r, a, rd_data[r*DW +: DW], RV);
    end

    // R2/R3: each write port to each address; same-cycle read sees old value.
    for (int p = 0; p < NW; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        idle(); wr_en[p] = 1'b1; wa[p] = AW'(a); wd[p] = pat(p, a);
        set_all_reads(a);
        check_reads("R3");
        tick(); idle();
        check_reads("R2");
      end
    end

    // R9: port 0 (bank 0) overwrites entries last written by port 3 (bank 1).
    for (int a = 0; a < DEPTH; a++) begin
      idle(); wr_en[0] = 1'b1; wa[0] = AW'(a); wd[0] = pat(9, a);
      tick(); idle(); set_all_reads(a); #1;
      for (int r = 0; r < NR; r++) cmp("R9", r, a, rd_data[r*DW +: DW], pat(9, a));
    end

    // R4: clashes within a pair, across pairs, and on all ports.
    idle(); wr_en = 4'b0011; wa[0] = 4'd5; wa[1] = 4'd5; wd[0] = 8'h11; wd[1] = 8'h22;
    tick(); idle(); set_all_reads(5); #1;
    cmp("R4", 0, 5, rd_data[0 +: DW], 8'h22);
    wr_en = 4'b0101; wa[0] = 4'd6; wa[2] = 4'd6; wd[0] = 8'h33; wd[2] = 8'h44;
    tick(); idle(); set_all_reads(6); #1;
    cmp("R4", 1, 6, rd_data[DW +: DW], 8'h44);
    wr_en = 4'b1111;
    for (int p = 0; p < NW; p++) begin wa[p] = 4'd7; wd[p] = DW'(8'h50 + p); end
    tick(); idle(); set_all_reads(7); #1;
    cmp("R4", 2, 7, rd_data[2*DW +: DW], 8'h53);

    // R5: masked invalidate of entries 0..7.
    idle(); inv_en = 1'b1; inv_mask = 16'h00FF;
    tick(); idle();
    for (int a = 0; a < DEPTH; a++) begin
      set_all_reads(a); #1;
      for (int r = 0; r < NR; r++)
        cmp("R5", r, a, rd_data[r*DW +: DW], (a < 8) ? RV : pat(9, a));
    end

    // R6: write on port 2 and full invalidate hit entry 3 together.
    idle(); inv_en = 1'b1; inv_mask = '1; wr_en[2] = 1'b1; wa[2] = 4'd3; wd[2] = 8'h3C;
    tick(); idle();
    set_all_reads(3); #1; cmp("R6", 0, 3, rd_data[0 +: DW], 8'h3C);
    set_all_reads(12); #1; cmp("R6", 1, 12, rd_data[DW +: DW], RV);

    // R8: address held and no activity keeps outputs steady.
    idle(); ra[0] = 4'd3; ra[1] = 4'd12; ra[2] = 4'd7; #1;
    for (int r = 0; r < NR; r++) hold[r] = rd_data[r*DW +: DW];
    for (int k = 0; k < 3; k++) begin
      tick(); #1;
      for (int r = 0; r < NR; r++) cmp("R8", r, ra[r], rd_data[r*DW +: DW], hold[r]);
    end

    // R7: pseudo-random mix, every read port checked every cycle.
    for (int n = 0; n < 1500; n++) begin
      idle();
      for (int p = 0; p < NW; p++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_en[p] = lfsr[0] & lfsr[3];
        wa[p] = lfsr[7:4];
        wd[p] = lfsr[15:8];
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inv_en = (lfsr[2:0] == 3'b000);
      inv_mask = {lfsr[7:0], lfsr[15:8]};
      for (int r = 0; r < NR; r++) ra[r] = AW'(lfsr >> (4 * r));
      check_reads("R7");
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule